// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a 32-bit timer that counts down and raises a maskable, level-sensitive interrupt each time it expires. Software uses a small word-addressed register bus to reach it. A control word holds the enable, the reload choice, the interrupt mask and a 12-bit prescaler. A load word supplies the period. A status word holds the single expiry flag, and a read-only port returns the live count.

Each counting step is paced by one of two tick-enable inputs: a fast peripheral tick or a slow 32 kHz tick. The prescaler divides the chosen tick by its value plus one. When the count passes through zero, the timer does one of two things. In reload mode it refills itself from the load word, which gives a periodic interrupt. Otherwise it wraps to all ones and runs on freely. Writes can force the count in two ways: enabling with the enable-mode bit clear loads the count, and a load write with the overwrite bit set loads it too. A compare word is kept for software but does not affect behaviour.

Top module: `pit_dn_timer`

## Requirements
- R1: Word addresses: 0 control, 1 status (flag at bit 0, other bits read 0), 2 load, 3 compare, 4 count (read-only). Reads of addresses 5 to 7 return 0. Writes to address 4 change nothing.
- R2: Control field positions are as follows. Bit 0 enables counting. Bit 1 is enable-mode. Bit 2 is the interrupt mask. Bit 3 selects reload. Bits 15:4 hold the prescaler. Bit 16 is a soft reset. Bit 17 is overwrite. Bits 25:24 select the source. A control write stores bits 25:0 except bit 16, which always reads 0; bits 31:26 read 0.
- R3: Source code 0 gives no ticks. Codes 1 and 2 take tick_fast, and code 3 takes tick_slow. While enabled, the count drops by one on every (prescaler+1)-th selected tick. The prescaler phase restarts on each control write.
- R4: A control write with bit 0 set and bit 1 clear loads the count from the load word. With bit 1 set, the count keeps its value. With bit 0 clear, the count freezes.
- R5: A counting step taken while the count is 0 sets the flag. It also moves the count to the load word if bit 3 is set, or to all ones if bit 3 is clear.
- R6: Any write to address 1 clears the flag. If an expiry happens on the same edge, the flag stays set.
- R7: irq is high exactly when the flag and control bit 2 are both set.
- R8: A load write also loads the count on the same edge when control bit 17 is set. Otherwise the count is unchanged and the new value is first used at the next reload.
- R9: Either rst_n low or a control write with bit 16 set has the same effect. Control, status and compare are cleared, and load and count become 0xFFFFFFFF. A soft-reset write then stores the rest of its own value.
- R10: The compare word is stored and read back. It does not alter the count, the flag or irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Peripheral-rate tick enable |
| tick_slow | input | 1 | 32 kHz tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Faults in the count show up on the count read-back and in where the flag appears. A wrong prescaler phase or a wrong decrement gives a different count after the very next selected tick. A wrong reload or wrap target is visible one step after the zero value. A wrong flag or mask shows on irq and on the status read in the cycle right after the edge that caused it. The bench sweeps small prescaler and period values step by step, so any off-by-one in the period length surfaces within the first period.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned PRE_W      = 12;
  localparam int unsigned SRC_W      = 2;
  localparam int unsigned CTL_EN     = 0;
  localparam int unsigned CTL_ENMODE = 1;
  localparam int unsigned CTL_IE     = 2;
  localparam int unsigned CTL_RLD    = 3;
  localparam int unsigned CTL_PRE_LO = 4;
  localparam int unsigned CTL_SWR    = 16;
  localparam int unsigned CTL_OVW    = 17;
  localparam int unsigned CTL_SRC_LO = 24;
  localparam int unsigned CTL_KEEP_W = 26;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_LOAD = 3'd2,
    A_CMP  = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF   = 2'd0,
    SRC_FAST0 = 2'd1,
    SRC_FAST1 = 2'd2,
    SRC_SLOW  = 2'd3
  } tick_src_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              flag_q,
  output logic              cnt_load,
  output logic [DATA_W-1:0] cnt_load_val,
  output logic              pre_clear
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (({{(DATA_W-1){1'b0}}, 1'b1} << CTL_KEEP_W) - 1'b1) & ~({{(DATA_W-1){1'b0}}, 1'b1} << CTL_SWR);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic wr_ctrl, wr_stat, wr_load, wr_cmp, soft_rst;
  logic [DATA_W-1:0] ctrl_d, load_d, cmp_d;
  logic flag_d;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_stat  = bus_wr && (bus_addr == A_STAT);
    wr_load  = bus_wr && (bus_addr == A_LOAD);
    wr_cmp   = bus_wr && (bus_addr == A_CMP);
    soft_rst = wr_ctrl && bus_wdata[CTL_SWR];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    cmp_d  = cmp_q;
    flag_d = flag_q;
    if (wr_stat) flag_d = 1'b0;
    if (expire)  flag_d = 1'b1;
    if (soft_rst) begin
      load_d = ALL_ONES;
      cmp_d  = '0;
      flag_d = 1'b0;
    end
    if (wr_ctrl) ctrl_d = bus_wdata & KEEP_MASK;
    if (wr_load) load_d = bus_wdata;
    if (wr_cmp)  cmp_d  = bus_wdata;
  end

  always_comb begin
    cnt_load = soft_rst
            || (wr_ctrl && bus_wdata[CTL_EN] && !bus_wdata[CTL_ENMODE])
            || (wr_load && ctrl_q[CTL_OVW]);
    if (wr_load)       cnt_load_val = bus_wdata;
    else if (soft_rst) cnt_load_val = ALL_ONES;
    else               cnt_load_val = load_q;
    pre_clear = wr_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  // R6: a status write without a simultaneous expiry leaves the flag clear
  p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !expire && !soft_rst) |=> !flag_q);
  // R5 / R6: an expiry always leaves the flag set
  p_expiry_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  // R9: soft reset restores load, compare and flag
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_load) |=> (load_q == ALL_ONES && cmp_q == '0 && !flag_q));
  // R2: the self-clearing reset bit never reads back as set
  p_swr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTL_SWR]);
endmodule

// File: rtl/pit_prescale.sv
module pit_prescale
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [SRC_W-1:0] src,
  input  logic             enable,
  input  logic [PRE_W-1:0] pre_div,
  input  logic             clear,
  output logic             step
);
  logic [PRE_W-1:0] phase_q, phase_d;
  logic             sel_tick, live_tick, wrap;

  always_comb begin
    unique case (tick_src_e'(src))
      SRC_OFF:   sel_tick = 1'b0;
      SRC_FAST0,
      SRC_FAST1: sel_tick = tick_fast;
      SRC_SLOW:  sel_tick = tick_slow;
      default:   sel_tick = 1'b0;
    endcase
  end

  always_comb begin
    live_tick = enable && sel_tick;
    wrap      = (phase_q == pre_div);
    step      = live_tick && wrap && !clear;
    phase_d   = phase_q;
    if (clear)          phase_d = '0;
    else if (live_tick) phase_d = wrap ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R3: the divider phase never runs past the programmed divisor
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= pre_div);
  // R3: no counting step without a selected tick
  p_step_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (enable && (tick_fast || tick_slow)));
endmodule

// File: rtl/pit_count.sv
module pit_count
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_req,
  input  logic [DATA_W-1:0] load_val,
  input  logic              reload_mode,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  logic [DATA_W-1:0] cnt_d;
  logic              at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = step && at_zero && !load_req;
    cnt_d   = cnt_q;
    if (load_req)    cnt_d = load_val;
    else if (step)   cnt_d = at_zero ? (reload_mode ? reload_val : ALL_ONES)
                                     : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ALL_ONES;
    else        cnt_q <= cnt_d;
  end

  // R3: a plain step lowers the count by exactly one
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4: with no step and no load the count holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_req) |=> $stable(cnt_q));
  // R5: wrap target in free-running mode
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_req && cnt_q == '0 && !reload_mode) |=> (cnt_q == ALL_ONES));
  // R5: reload target in periodic mode
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_req && cnt_q == '0 && reload_mode) |=> (cnt_q == $past(reload_val)));
  // R8 / R4: a forced load lands on the next edge
  p_forced_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/pit_dn_timer.sv
module pit_dn_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, load_q, cmp_q, cnt_q, cnt_load_val;
  logic              flag_q, cnt_load, pre_clear, step, expire;

  pit_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .expire       (expire),
    .ctrl_q       (ctrl_q),
    .load_q       (load_q),
    .cmp_q        (cmp_q),
    .flag_q       (flag_q),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .pre_clear    (pre_clear)
  );

  pit_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .src       (ctrl_q[CTL_SRC_LO +: SRC_W]),
    .enable    (ctrl_q[CTL_EN]),
    .pre_div   (ctrl_q[CTL_PRE_LO +: PRE_W]),
    .clear     (pre_clear),
    .step      (step)
  );

  pit_count u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .load_req    (cnt_load),
    .load_val    (cnt_load_val),
    .reload_mode (ctrl_q[CTL_RLD]),
    .reload_val  (load_q),
    .cnt_q       (cnt_q),
    .expire      (expire)
  );

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      A_LOAD:  bus_rdata = load_q;
      A_CMP:   bus_rdata = cmp_q;
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
    irq = flag_q && ctrl_q[CTL_IE];
  end

  // R7: a status write with no expiry drops the interrupt on the next edge
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && !expire) |=> !irq);
  // R7: an expiry with the mask already open raises the interrupt
  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q[CTL_IE] && !(bus_wr && bus_addr == A_CTRL)) |=> irq);
endmodule

// File: tb/pit_dn_timer_tb_top.sv
module pit_dn_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  int          checks = 0, fails = 0;
  bit          done = 0;

  localparam logic [31:0] EN = 32'h1, ENM = 32'h2, IE = 32'h4, RLD = 32'h8,
                          SWR = 32'h1_0000, OVW = 32'h2_0000;
  localparam logic [31:0] S1 = 32'h0100_0000, S2 = 32'h0200_0000, S3 = 32'h0300_0000;

  pit_dn_timer dut_i (.clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n, input bit slow);
    @(negedge clk);
    if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
    repeat (n) @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 hardware reset state
    rd(0, v); chk("R9 ctrl after reset", v, 0);
    rd(1, v); chk("R9 status after reset", v, 0);
    rd(2, v); chk("R9 load after reset", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R9 compare after reset", v, 0);
    rd(4, v); chk("R9 count after reset", v, 32'hFFFF_FFFF);
    chk("R7 irq after reset", irq, 0);

    // R3 / R5 sweep: prescaler 0..3, period 0..3, reload mode
    for (int p = 0; p < 4; p++) begin
      for (int l = 0; l < 4; l++) begin
        wr(0, SWR);
        wr(2, l);
        wr(0, EN | RLD | S1 | (p << 4));
        rd(4, v); chk("R4 enable loads count", v, l);
        for (int k = 1; k <= 2 * (l + 1) * (p + 1) + 1; k++) begin
          int d;
          ticks(1, 0);
          d = k / (p + 1);
          rd(4, v); chk("R3 R5 periodic count", v, l - (d % (l + 1)));
          rd(1, v); chk("R5 flag after expiry", v, (d >= l + 1) ? 1 : 0);
          chk("R7 irq masked", irq, 0);
        end
      end
    end

    // R5 free-running wrap
    wr(0, SWR); wr(2, 2); wr(0, EN | S1);
    ticks(3, 0);
    rd(4, v); chk("R5 wrap to all ones", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R5 flag on wrap", v, 1);
    ticks(1, 0);
    rd(4, v); chk("R5 count after wrap", v, 32'hFFFF_FFFE);

    // R7 interrupt mask and R6 clear
    wr(0, EN | ENM | IE | S1);
    chk("R7 irq when flag and mask", irq, 1);
    wr(1, 0);
    chk("R6 R7 status write clears", irq, 0);
    rd(1, v); chk("R6 flag cleared", v, 0);

    // R6 expiry and status write on the same edge
    wr(0, SWR); wr(2, 0); wr(0, EN | IE | RLD | S1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 1; bus_wdata = 0; tick_fast = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick_fast = 1'b0;
    rd(1, v); chk("R6 set wins over clear", v, 1);
    chk("R7 irq on same-edge set", irq, 1);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R6 any status write clears", v, 0);

    // R4 enable, freeze, enable-mode
    wr(0, SWR); wr(2, 10); wr(0, EN | RLD | S1);
    ticks(3, 0);
    rd(4, v); chk("R4 running count", v, 7);
    wr(0, RLD | S1);
    ticks(5, 0);
    rd(4, v); chk("R4 frozen when disabled", v, 7);
    wr(0, EN | ENM | RLD | S1);
    rd(4, v); chk("R4 enable-mode keeps count", v, 7);
    ticks(2, 0);
    rd(4, v); chk("R4 resumes from held count", v, 5);
    wr(0, EN | RLD | S1);
    rd(4, v); chk("R4 re-enable reloads", v, 10);

    // R8 load writes with and without overwrite
    wr(2, 4);
    rd(4, v); chk("R8 load write without overwrite", v, 10);
    rd(2, v); chk("R8 load word stored", v, 4);
    ticks(11, 0);
    rd(4, v); chk("R8 new load used at reload", v, 4);
    wr(0, EN | ENM | RLD | OVW | S1);
    ticks(1, 0);
    wr(2, 20);
    rd(4, v); chk("R8 overwrite loads count", v, 20);

    // R3 clock sources
    wr(0, SWR); wr(2, 100); wr(0, EN | RLD);
    ticks(5, 0); ticks(5, 1);
    rd(4, v); chk("R3 source 0 does not count", v, 100);
    wr(0, EN | ENM | RLD | S3);
    ticks(5, 0);
    rd(4, v); chk("R3 source 3 ignores fast tick", v, 100);
    ticks(4, 1);
    rd(4, v); chk("R3 source 3 counts slow tick", v, 96);
    wr(0, EN | ENM | RLD | S2);
    ticks(3, 0); ticks(3, 1);
    rd(4, v); chk("R3 source 2 counts fast only", v, 93);

    // R10 compare has no effect
    wr(0, SWR); wr(3, 3); wr(2, 6); wr(0, EN | IE | RLD | S1);
    ticks(4, 0);
    rd(3, v); chk("R10 compare stored", v, 3);
    rd(4, v); chk("R10 count passes compare", v, 2);
    rd(1, v); chk("R10 no flag at compare", v, 0);
    chk("R10 no irq at compare", irq, 0);

    // R1 map details
    wr(4, 32'h55);
    rd(4, v); chk("R1 count write ignored", v, 2);
    rd(5, v); chk("R1 address 5 reads zero", v, 0);
    rd(6, v); chk("R1 address 6 reads zero", v, 0);
    rd(7, v); chk("R1 address 7 reads zero", v, 0);

    // R2 / R9 soft reset with stored fields
    wr(0, 32'hFFFF_FFFE);
    rd(0, v); chk("R2 stored control bits", v, 32'h03FE_FFFE);
    rd(2, v); chk("R9 soft reset load", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R9 soft reset compare", v, 0);
    rd(4, v); chk("R9 soft reset count", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R9 soft reset flag", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule